// File: doc/BRIEF.md
# Configuration Image Checksum Checker

This block validates a configuration image as it streams out of a serial EEPROM reader. The image is a run of 16-bit words. The final word carries a stored checksum, and the source marks that word with a last flag. The checker adds every word before the final one into a wide accumulator. When the final word arrives, it compares the low half-word of the sum against that word and raises a one-cycle done pulse together with a verdict.

A sum of zero is always treated as a corrupt image, because a blank or all-zero device would otherwise pass. An image shorter than two words is malformed, and so is an image longer than the configured maximum. Both cases are reported as length errors. After each verdict the checker rearms on its own for the next image. A clear input abandons any image that is in progress.

Top module: `cfg_image_sum_check`

## Requirements
- R1: Every accepted word before the word flagged last is added into an accumulator of ACC_W bits (at least 32). The last word is never added.
- R2: For a well-formed image with a nonzero full sum, pass_o is 1 exactly when sum[15:0] equals the last word. zero_err_o and len_err_o are 0.
- R3: If the full ACC_W-bit sum is zero, the verdict is pass_o=0 and zero_err_o=1, even when the stored word is 0x0000.
- R4: Carries above bit 15 do not take part in the compare. They only make the sum nonzero. Example: words 0x8000,0x8000 with stored 0x0000 give pass_o=1.
- R5: done_o is high for exactly one cycle, in the cycle after the clock edge that accepts the last word. Verdict outputs are valid in that cycle.
- R6: If the last flag arrives on the first word of an image, the verdict is len_err_o=1, pass_o=0, zero_err_o=0.
- R7: If an image has more than MAX_WORDS words, the verdict is len_err_o=1 and pass_o=0. An image of exactly MAX_WORDS words is checked normally.
- R8: clear_i zeroes the accumulator and the word count, and resets pass_o, zero_err_o and len_err_o to 0. It takes priority over a word offered in the same cycle, which is dropped.
- R9: word_i and word_last_i are ignored while word_valid_i is 0.
- R10: The verdict outputs hold their value until the next done pulse or clear.
- R11: After a verdict the next accepted word starts a new image, with the accumulator and count at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clear_i | input | 1 | Abandon the current image and clear the verdict |
| word_valid_i | input | 1 | word_i is offered this cycle |
| word_i | input | 16 | Image word |
| word_last_i | input | 1 | The offered word is the stored checksum |
| done_o | output | 1 | One-cycle verdict strobe |
| pass_o | output | 1 | Checksum matched |
| zero_err_o | output | 1 | Full sum was zero |
| len_err_o | output | 1 | Image too short or too long |

## Verification
Each word is accepted on the rising edge where word_valid_i is high. The verdict sits one register stage behind that edge, so done_o and the three flags are due in the first cycle after the last word is taken, and done_o must be low again one cycle later. The bench drives inputs on the falling edge and samples on the next falling edge. It therefore checks the verdict half a cycle after the edge that should have produced it. It then checks done_o once more one cycle later, and checks that the flags still hold after idle cycles or after a clear.

// File: rtl/cfg_sum_pkg.sv
// Shared types for the configuration image checksum checker.
// Assumes nothing beyond standard SystemVerilog packages.
package cfg_sum_pkg;

    // Verdict produced once per image.
    typedef struct packed {
        logic pass;
        logic zero_err;
        logic len_err;
    } cfg_verdict_t;

    localparam cfg_verdict_t VERDICT_NONE = '{pass: 1'b0, zero_err: 1'b0, len_err: 1'b0};

endpackage

// File: rtl/cfg_sum_acc.sv
// Running sum of image words.
// Adds each accepted word that is not flagged last; zeroes on clear or after
// the last word so the next image starts fresh. Assumes ACC_W > WORD_W.
module cfg_sum_acc #(
    parameter int WORD_W = 16,
    parameter int ACC_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              add_i,     // accepted non-last word that counts
    input  logic              end_i,     // accepted last word
    input  logic [WORD_W-1:0] word_i,
    output logic [ACC_W-1:0]  sum_o
);

    localparam int PAD_W = ACC_W - WORD_W;

    logic [ACC_W-1:0] sum_q;
    logic [ACC_W-1:0] sum_d;

    // Next-sum selection: clear and image end win over accumulation.
    always_comb begin
        sum_d = sum_q;
        if (clear_i || end_i) begin
            sum_d = '0;
        end else if (add_i) begin
            sum_d = sum_q + {{PAD_W{1'b0}}, word_i};
        end
    end

    // Accumulator register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q <= '0;
        end else begin
            sum_q <= sum_d;
        end
    end

    assign sum_o = sum_q;

    // R8
    acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (sum_q == '0));

    // R11
    acc_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (end_i && !clear_i) |=> (sum_q == '0));

    // R9
    acc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!add_i && !end_i && !clear_i) |=> $stable(sum_q));

endmodule

// File: rtl/cfg_sum_len.sv
// Image length tracker.
// Counts the words that precede the last one, saturating at MAX_WORDS-1, and
// raises a sticky overflow once a further non-last word shows up. Produces the
// add enable for the accumulator and the length verdict. Assumes MAX_WORDS >= 2.
module cfg_sum_len #(
    parameter int MAX_WORDS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic take_i,      // a word is accepted this cycle
    input  logic last_i,      // the accepted word is flagged last
    output logic add_o,       // word should be summed
    output logic end_o,       // last word accepted
    output logic len_bad_o    // image length out of range (valid with end_o)
);

    localparam int CNT_MAX = MAX_WORDS - 1;
    localparam int CNT_W   = $clog2(MAX_WORDS);

    logic [CNT_W-1:0] cnt_q;
    logic             ovf_q;
    logic             at_max;

    assign at_max = (cnt_q == CNT_W'(CNT_MAX));
    assign end_o  = take_i && last_i && !clear_i;
    assign add_o  = take_i && !last_i && !clear_i && !at_max && !ovf_q;
    assign len_bad_o = ovf_q || (cnt_q == '0);

    // Preceding-word counter and overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i || end_o) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else if (take_i && !last_i) begin
            if (at_max) begin
                ovf_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R7
    len_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q <= CNT_W'(CNT_MAX)));

    // R7
    len_ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !clear_i && !end_o) |=> ovf_q);

endmodule

// File: rtl/cfg_sum_verdict.sv
// Verdict logic and result registers.
// Judges the finished sum against the stored word, registers the verdict and
// emits a one-cycle done strobe. Holds the verdict until the next image end or
// a clear. Assumes sum_i already excludes the stored word.
module cfg_sum_verdict
    import cfg_sum_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int ACC_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              end_i,
    input  logic              len_bad_i,
    input  logic [ACC_W-1:0]  sum_i,
    input  logic [WORD_W-1:0] stored_i,
    output logic              done_o,
    output cfg_verdict_t      verdict_o
);

    cfg_verdict_t judge;
    cfg_verdict_t verdict_q;
    logic         done_q;

    // Priority: length error, then zero sum, then low half-word compare.
    always_comb begin
        judge = VERDICT_NONE;
        if (len_bad_i) begin
            judge.len_err = 1'b1;
        end else if (sum_i == '0) begin
            judge.zero_err = 1'b1;
        end else begin
            judge.pass = (sum_i[WORD_W-1:0] == stored_i);
        end
    end

    // Verdict and strobe registers.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            verdict_q <= VERDICT_NONE;
            done_q    <= 1'b0;
        end else begin
            done_q <= end_i;
            if (end_i) begin
                verdict_q <= judge;
            end
        end
    end

    assign done_o    = done_q;
    assign verdict_o = verdict_q;

    // R5
    done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> $past(end_i && !clear_i));

    // R10
    verdict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_q && !$past(clear_i)) |-> $stable(verdict_q));

    // R2
    verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({verdict_q.pass, verdict_q.zero_err, verdict_q.len_err}));

    // R8
    verdict_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (!done_q && verdict_q == VERDICT_NONE));

endmodule

// File: rtl/cfg_image_sum_check.sv
// Configuration image checksum checker (top).
// Accepts a stream of 16-bit words, sums all but the word flagged last, and
// reports whether the low half-word of the sum matches that stored word.
// Assumes the source holds word_i and word_last_i stable while word_valid_i is high.
module cfg_image_sum_check
    import cfg_sum_pkg::*;
#(
    parameter int MAX_WORDS = 32,
    parameter int ACC_W     = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear_i,
    input  logic        word_valid_i,
    input  logic [15:0] word_i,
    input  logic        word_last_i,
    output logic        done_o,
    output logic        pass_o,
    output logic        zero_err_o,
    output logic        len_err_o
);

    localparam int WORD_W = 16;

    logic             add_w;
    logic             end_w;
    logic             len_bad_w;
    logic [ACC_W-1:0] sum_w;
    cfg_verdict_t     verdict_w;

    cfg_sum_len #(
        .MAX_WORDS (MAX_WORDS)
    ) u_len (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (clear_i),
        .take_i    (word_valid_i),
        .last_i    (word_last_i),
        .add_o     (add_w),
        .end_o     (end_w),
        .len_bad_o (len_bad_w)
    );

    cfg_sum_acc #(
        .WORD_W (WORD_W),
        .ACC_W  (ACC_W)
    ) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear_i),
        .add_i   (add_w),
        .end_i   (end_w),
        .word_i  (word_i),
        .sum_o   (sum_w)
    );

    cfg_sum_verdict #(
        .WORD_W (WORD_W),
        .ACC_W  (ACC_W)
    ) u_verdict (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (clear_i),
        .end_i     (end_w),
        .len_bad_i (len_bad_w),
        .sum_i     (sum_w),
        .stored_i  (word_i),
        .done_o    (done_o),
        .verdict_o (verdict_w)
    );

    assign pass_o     = verdict_w.pass;
    assign zero_err_o = verdict_w.zero_err;
    assign len_err_o  = verdict_w.len_err;

    // R5
    done_follows_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid_i && word_last_i && !clear_i) |=> done_o);

    // R9
    no_done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid_i |=> !done_o);

    // R6
    short_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && len_err_o) |-> !pass_o);

endmodule

// File: tb/cfg_image_sum_check_test.sv
// Directed bench for the configuration image checksum checker.
module cfg_image_sum_check_test;

    localparam int MAXW = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clear_i = 1'b0;
    logic        word_valid_i = 1'b0;
    logic [15:0] word_i = '0;
    logic        word_last_i = 1'b0;
    logic        done_o, pass_o, zero_err_o, len_err_o;

    int n_checks = 0;
    int n_fail   = 0;
    logic [15:0] img [0:39];

    always #10 clk = ~clk;

    cfg_image_sum_check #(.MAX_WORDS(MAXW), .ACC_W(32)) uut (
        .clk(clk), .rst_n(rst_n), .clear_i(clear_i),
        .word_valid_i(word_valid_i), .word_i(word_i), .word_last_i(word_last_i),
        .done_o(done_o), .pass_o(pass_o), .zero_err_o(zero_err_o), .len_err_o(len_err_o)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Verdict outputs packed as {done, pass, zero, len}.
    function automatic logic [3:0] outs();
        return {done_o, pass_o, zero_err_o, len_err_o};
    endfunction

    // Drive n words from img (last flagged) with optional idle gap, then check.
    task automatic run_image(input int n, input int gap, input string req);
        logic [31:0] sum = 0;
        logic [3:0]  exp;
        for (int i = 0; i < n; i++) begin
            word_valid_i = 1'b1;
            word_i       = img[i];
            word_last_i  = (i == n - 1);
            if (i < n - 1) sum += {16'h0, img[i]};
            @(negedge clk);
            if (gap > 0 && i < n - 1) begin
                word_valid_i = 1'b0;
                word_i       = 16'hDEAD;
                word_last_i  = 1'b1;
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk);
                    check(req, "done during gap", {31'h0, done_o}, 32'h0);
                end
            end
        end
        word_valid_i = 1'b0;
        word_last_i  = 1'b0;
        if (n < 2 || n > MAXW)      exp = 4'b1001;
        else if (sum == 0)          exp = 4'b1010;
        else if (sum[15:0] == img[n-1]) exp = 4'b1100;
        else                        exp = 4'b1000;
        check(req, "verdict {done,pass,zero,len}", {28'h0, outs()}, {28'h0, exp});
        @(negedge clk);
        check("R5", "done one cycle only", {31'h0, done_o}, 32'h0);
        check("R10", "verdict held", {29'h0, outs()[2:0]}, {29'h0, exp[2:0]});
    endtask

    task automatic t_reset();
        check("R8", "reset outputs", {28'h0, outs()}, 32'h0);
    endtask

    task automatic t_basic();
        img[0] = 16'h1234; img[1] = 16'h0101; img[2] = 16'h1335;
        run_image(3, 0, "R2");
        img[2] = 16'h1336;
        run_image(3, 0, "R2");
        img[0] = 16'h0007; img[1] = 16'h0007;
        run_image(2, 0, "R1");
    endtask

    task automatic t_zero();
        img[0] = 16'h0; img[1] = 16'h0; img[2] = 16'h0;
        run_image(3, 0, "R3");
        img[0] = 16'h8000; img[1] = 16'h8000; img[2] = 16'h0;
        run_image(3, 0, "R4");
        img[0] = 16'hFFFF; img[1] = 16'hFFFF; img[2] = 16'hFFFF; img[3] = 16'hFFFD;
        run_image(4, 0, "R4");
    endtask

    task automatic t_len();
        img[0] = 16'h0000;
        run_image(1, 0, "R6");
        for (int i = 0; i < MAXW - 1; i++) img[i] = 16'(i * 3 + 1);
        img[MAXW-1] = 16'(((MAXW - 1) * (3 * (MAXW - 2) + 2)) / 2);
        run_image(MAXW, 0, "R7");
        check("R7", "exact max passes", {31'h0, pass_o}, 32'h1);
        for (int i = 0; i < MAXW; i++) img[i] = 16'h0001;
        img[MAXW] = 16'(MAXW);
        run_image(MAXW + 1, 0, "R7");
    endtask

    task automatic t_gap();
        img[0] = 16'h00AA; img[1] = 16'h0055; img[2] = 16'h00FF;
        run_image(3, 3, "R9");
    endtask

    task automatic t_clear();
        // partial image then clear
        word_valid_i = 1'b1; word_i = 16'h4444; word_last_i = 1'b0;
        @(negedge clk);
        clear_i = 1'b1; word_i = 16'h7777;
        @(negedge clk);
        clear_i = 1'b0; word_valid_i = 1'b0;
        check("R8", "outputs after clear", {28'h0, outs()}, 32'h0);
        img[0] = 16'h0010; img[1] = 16'h0010;
        run_image(2, 0, "R8");
        // clear while a last word is offered: no verdict
        word_valid_i = 1'b1; word_i = 16'h0001; word_last_i = 1'b1; clear_i = 1'b1;
        @(negedge clk);
        word_valid_i = 1'b0; word_last_i = 1'b0; clear_i = 1'b0;
        check("R8", "clear beats last", {28'h0, outs()}, 32'h0);
        // next image fresh after a verdict
        img[0] = 16'h0003; img[1] = 16'h0003;
        run_image(2, 0, "R11");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_zero();
        t_len();
        t_gap();
        t_clear();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule